// File: doc/BRIEF.md
# Frame-Aware Receive Buffer with Dropped-Frame Counter

This block sits between a MAC receive path and a host. Bytes of each received frame arrive one per cycle, with an end-of-frame marker, and cannot be held off. They land first in a fixed-size staging FIFO. A mover takes them out of staging and writes them into a larger host-facing byte store whenever that store has room. The data of a frame becomes visible to the host only once its last byte has reached the store. At that point a one-word status entry holding the frame length in bytes goes into a status FIFO. The host reads the status entry first and then the frame bytes. It may abandon the rest of a frame with a self-clearing fast-forward request.

The receive side is run by the FSM `RX_IDLE` / `RX_PASS` / `RX_DROP`:
- `RX_IDLE -> RX_PASS` on the first byte of a frame that is accepted.
- `RX_IDLE -> RX_DROP` on the first byte of a frame that is refused.
- `RX_PASS -> RX_DROP` on an overrun in the middle of a frame.
- `RX_PASS -> RX_IDLE` and `RX_DROP -> RX_IDLE` on an end-of-frame byte.
- A one-byte frame leaves the FSM in `RX_IDLE`.

An overrun is a byte arriving while staging is full and nothing leaves staging that cycle. It discards the whole frame: the frame's bytes already moved are rewound out of the store, and the bytes still in staging are cut off. After an overrun every later frame is refused until the host frees space by reading. A saturating counter, cleared by a read strobe, counts every refused or discarded frame.

The fast-forward FSM has two states, `FF_IDLE` and `FF_JUMP`. `FF_IDLE -> FF_JUMP` on a request while bytes of the current frame remain. `FF_JUMP -> FF_IDLE` always, after one cycle, with the read pointer moved past those bytes. An information word reports how many committed bytes are in the store and how many status entries are waiting.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, `fifo_info`, `drop_count` and `ffwd_busy` are all 0.
- R2: Frames reach the host in arrival order with their bytes intact. The status word at the head of the status FIFO (`sts_data`, bits 15:0) equals the length of the head frame in bytes.
- R3: `fifo_info[15:0]` is the number of committed bytes in the data store. `fifo_info[23:16]` is the number of waiting status entries, each one DWORD. `fifo_info[31:24]` is 0.
- R4: Bytes of a frame do not count in `fifo_info[15:0]` until the frame's last byte has reached the store. Bytes held in staging or partly moved are never counted. With a frame sent back to back, the count rises by the frame length one cycle after the last byte is accepted.
- R5: A byte arriving while staging holds `STG_DEPTH` bytes and no byte leaves staging that cycle overruns. The whole frame is discarded, no status entry is written, and complete frames received earlier are kept.
- R6: After an overrun, every following frame is refused whole until the host pops a data byte or completes a fast-forward. Frames after that are accepted again.
- R7: Every refused or discarded frame adds exactly 1 to `drop_count`, which holds at 2^CNT_W-1.
- R8: A cycle with `drop_rd` high clears `drop_count` to 0 at the next edge. If a frame is dropped in that same cycle, the counter becomes 1.
- R9: A `ffwd_set` pulse while bytes of the current frame (the one whose status was last popped) remain moves the read pointer past them. The next byte presented on `host_data` is the first byte of the next frame.
- R10: `ffwd_busy` is 1 for exactly the one cycle after an accepted fast-forward request and then 0. `host_rd` has no effect during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_valid | input | 1 | A receive byte is present this cycle |
| mac_data | input | 8 | Receive byte |
| mac_last | input | 1 | This byte ends its frame |
| host_rd | input | 1 | Pop one byte from the data store |
| host_data | output | 8 | Byte at the head of the data store |
| sts_rd | input | 1 | Pop the head status entry |
| sts_data | output | 16 | Length in bytes of the head status entry |
| ffwd_set | input | 1 | Request skip of the rest of the current frame |
| ffwd_busy | output | 1 | Fast-forward in progress |
| fifo_info | output | 32 | {8'h0, status entries, committed data bytes} |
| drop_rd | input | 1 | Read strobe that clears the drop counter |
| drop_count | output | CNT_W | Saturating dropped-frame count |

## Verification
A rewind to the wrong pointer shows up as misplaced bytes on `host_data`. It can show up in two ways: a kept earlier frame loses its tail, or fragments of the discarded frame appear in front of the next good frame. The byte-by-byte scoreboard catches this on the first byte the host reads after the overrun. A wrong commit point shows in `fifo_info[15:0]` one cycle after a frame ends, so the count is sampled exactly on the cycle the last byte lands. A stale blocked flag or a wrong counter step shows on `drop_count` as soon as the next frame finishes arriving.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_PASS, RX_DROP} rx_state_e;
    typedef enum logic {FF_IDLE, FF_JUMP} ff_state_e;
    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } stg_word_t;
endpackage

// File: rtl/rxfb_ingress.sv
module rxfb_ingress
    import rxfb_pkg::*;
#(
    parameter int unsigned STG_DEPTH = 128,
    parameter int unsigned CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mac_valid,
    input  logic [7:0]       mac_data,
    input  logic             mac_last,
    input  logic             pop,
    input  logic             room_freed,
    input  logic             drop_rd,
    output logic             stg_empty,
    output stg_word_t        head,
    output logic             rewind_data,
    output logic [CNT_W-1:0] drop_count
);
    localparam int unsigned SAW = $clog2(STG_DEPTH);
    localparam logic [SAW:0] SCAP = (SAW+1)'(STG_DEPTH);
    localparam logic [CNT_W-1:0] CMAX = '1;

    stg_word_t        mem [STG_DEPTH];
    logic [SAW:0]     wr, rd, fstart, pend, used;
    logic             blocked, overrun;
    logic             do_store, do_start, do_count, do_abort;
    rx_state_e        st, st_nx;

    assign used      = wr - rd;
    assign stg_empty = (used == '0);
    assign head      = mem[rd[SAW-1:0]];
    assign overrun   = mac_valid && (used == SCAP) && !pop;

    always_comb begin
        st_nx    = st;
        do_store = 1'b0;
        do_start = 1'b0;
        do_count = 1'b0;
        do_abort = 1'b0;
        unique case (st)
            RX_IDLE: if (mac_valid) begin
                if (blocked || overrun) begin
                    do_count = 1'b1;
                    if (!mac_last) st_nx = RX_DROP;
                end else begin
                    do_store = 1'b1;
                    do_start = 1'b1;
                    if (!mac_last) st_nx = RX_PASS;
                end
            end
            RX_PASS: if (mac_valid) begin
                if (overrun) begin
                    do_count = 1'b1;
                    do_abort = 1'b1;
                    st_nx    = mac_last ? RX_IDLE : RX_DROP;
                end else begin
                    do_store = 1'b1;
                    if (mac_last) st_nx = RX_IDLE;
                end
            end
            RX_DROP: if (mac_valid && mac_last) st_nx = RX_IDLE;
            default: st_nx = RX_IDLE;
        endcase
    end

    assign rewind_data = do_abort && (pend == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (do_store) mem[wr[SAW-1:0]] <= '{last: mac_last, data: mac_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr <= '0; rd <= '0; fstart <= '0; pend <= '0; blocked <= 1'b0;
        end else begin
            if (do_store) begin
                wr <= wr + (SAW+1)'(1);
                if (do_start) fstart <= wr;
            end else if (do_abort) begin
                wr <= (pend != '0) ? fstart : rd;
            end
            if (pop) rd <= rd + (SAW+1)'(1);
            pend <= pend + (SAW+1)'(do_store && mac_last) - (SAW+1)'(pop && head.last);
            if (overrun && st != RX_DROP) blocked <= 1'b1;
            else if (room_freed)          blocked <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           drop_count <= '0;
        else if (drop_rd)     drop_count <= do_count ? CNT_W'(1) : '0;
        else if (do_count && drop_count != CMAX)
                              drop_count <= drop_count + CNT_W'(1);
    end

    a_r5_stg_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr - rd) <= SCAP);
    a_r7_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_rd |=> drop_count >= $past(drop_count));
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_rd |=> (drop_count - $past(drop_count)) <= CNT_W'(1));
endmodule

// File: rtl/rxfb_store.sv
module rxfb_store
    import rxfb_pkg::*;
#(
    parameter int unsigned DATA_DEPTH = 512,
    parameter int unsigned STS_DEPTH  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [7:0]  push_data,
    input  logic        push_last,
    input  logic        rewind,
    input  logic        host_rd,
    output logic [7:0]  host_data,
    input  logic        sts_rd,
    output logic [15:0] sts_data,
    input  logic        ffwd_req,
    output logic        ffwd_busy,
    output logic        room,
    output logic        sts_full,
    output logic        room_freed,
    output logic [15:0] data_used,
    output logic [7:0]  sts_used
);
    localparam int unsigned AW = $clog2(DATA_DEPTH);
    localparam int unsigned SW = $clog2(STS_DEPTH);
    localparam logic [AW:0] DCAP = (AW+1)'(DATA_DEPTH);
    localparam logic [SW:0] SCAP = (SW+1)'(STS_DEPTH);

    logic [7:0]  mem  [DATA_DEPTH];
    logic [15:0] smem [STS_DEPTH];
    logic [AW:0] wr, cm, rd, committed;
    logic [SW:0] swr, srd;
    logic [15:0] flen, rem;
    logic        rd_ok, sts_ok;
    ff_state_e   ff_st, ff_nx;

    assign committed  = cm - rd;
    assign room       = (wr - rd) != DCAP;
    assign sts_full   = (swr - srd) == SCAP;
    assign host_data  = mem[rd[AW-1:0]];
    assign sts_data   = smem[srd[SW-1:0]];
    assign data_used  = 16'(committed);
    assign sts_used   = 8'(swr - srd);
    assign ffwd_busy  = (ff_st == FF_JUMP);
    assign rd_ok      = host_rd && committed != '0 && ff_st == FF_IDLE;
    assign sts_ok     = sts_rd && swr != srd && ff_st == FF_IDLE;
    assign room_freed = rd_ok || ff_st == FF_JUMP;

    always_comb begin
        ff_nx = ff_st;
        unique case (ff_st)
            FF_IDLE: if (ffwd_req && rem != '0) ff_nx = FF_JUMP;
            FF_JUMP: ff_nx = FF_IDLE;
            default: ff_nx = FF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ff_st <= FF_IDLE;
        else        ff_st <= ff_nx;
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr[AW-1:0]] <= push_data;
        if (push && push_last) smem[swr[SW-1:0]] <= flen + 16'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr <= '0; cm <= '0; rd <= '0; swr <= '0; srd <= '0;
            flen <= '0; rem <= '0;
        end else begin
            if (push) begin
                wr <= wr + (AW+1)'(1);
                if (push_last) begin
                    cm   <= wr + (AW+1)'(1);
                    swr  <= swr + (SW+1)'(1);
                    flen <= '0;
                end else begin
                    flen <= flen + 16'd1;
                end
            end else if (rewind) begin
                wr   <= cm;
                flen <= '0;
            end
            if (ff_st == FF_JUMP) rd <= rd + (AW+1)'(rem);
            else if (rd_ok)       rd <= rd + (AW+1)'(1);
            if (sts_ok) srd <= srd + (SW+1)'(1);
            if (ff_st == FF_JUMP)       rem <= '0;
            else if (sts_ok)            rem <= sts_data;
            else if (rd_ok && rem != '0) rem <= rem - 16'd1;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr - rd) <= DCAP);
    a_r4_commit_inside: assert property (@(posedge clk) disable iff (!rst_n)
        committed <= (wr - rd));
    a_r9_jump_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ff_st == FF_JUMP |=> rem == '0);
    a_r10_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
        ffwd_busy |=> !ffwd_busy);
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
    import rxfb_pkg::*;
#(
    parameter int unsigned STG_DEPTH  = 128,
    parameter int unsigned DATA_DEPTH = 512,
    parameter int unsigned STS_DEPTH  = 32,
    parameter int unsigned CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mac_valid,
    input  logic [7:0]       mac_data,
    input  logic             mac_last,
    input  logic             host_rd,
    output logic [7:0]       host_data,
    input  logic             sts_rd,
    output logic [15:0]      sts_data,
    input  logic             ffwd_set,
    output logic             ffwd_busy,
    output logic [31:0]      fifo_info,
    input  logic             drop_rd,
    output logic [CNT_W-1:0] drop_count
);
    stg_word_t   head;
    logic        stg_empty, room, sts_full, room_freed, rewind, pop;
    logic [15:0] data_used;
    logic [7:0]  sts_used;

    assign pop       = !stg_empty && room && !(head.last && sts_full);
    assign fifo_info = {8'h00, sts_used, data_used};

    rxfb_ingress #(.STG_DEPTH(STG_DEPTH), .CNT_W(CNT_W)) u_ingress (
        .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_data(mac_data),
        .mac_last(mac_last), .pop(pop), .room_freed(room_freed),
        .drop_rd(drop_rd), .stg_empty(stg_empty), .head(head),
        .rewind_data(rewind), .drop_count(drop_count)
    );

    rxfb_store #(.DATA_DEPTH(DATA_DEPTH), .STS_DEPTH(STS_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(pop), .push_data(head.data),
        .push_last(head.last), .rewind(rewind), .host_rd(host_rd),
        .host_data(host_data), .sts_rd(sts_rd), .sts_data(sts_data),
        .ffwd_req(ffwd_set), .ffwd_busy(ffwd_busy), .room(room),
        .sts_full(sts_full), .room_freed(room_freed),
        .data_used(data_used), .sts_used(sts_used)
    );

    a_r5_no_move_on_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |-> !pop);
    a_r3_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_info[31:24] == 8'h00);
endmodule

// File: tb/rx_frame_buffer_tb.sv
module rx_frame_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mac_valid = 1'b0, mac_last = 1'b0, host_rd = 1'b0, sts_rd = 1'b0;
    logic ffwd_set = 1'b0, drop_rd = 1'b0;
    logic [7:0] mac_data = '0, host_data;
    logic [15:0] sts_data;
    logic ffwd_busy;
    logic [31:0] fifo_info;
    logic [CNT_W-1:0] drop_count;

    int n_run = 0, n_fail = 0;
    logic [7:0] exp_bytes[$];
    int exp_lens[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_buffer #(.STG_DEPTH(128), .DATA_DEPTH(64), .STS_DEPTH(8), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_data(mac_data),
        .mac_last(mac_last), .host_rd(host_rd), .host_data(host_data),
        .sts_rd(sts_rd), .sts_data(sts_data), .ffwd_set(ffwd_set),
        .ffwd_busy(ffwd_busy), .fifo_info(fifo_info), .drop_rd(drop_rd),
        .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: sends one frame, queues it for the scoreboard if it should survive
    task automatic send_frame(input int n, input bit keep, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mac_valid = 1'b1;
            mac_data  = 8'(seed + i);
            mac_last  = (i == n - 1);
            if (keep) exp_bytes.push_back(8'(seed + i));
        end
        if (keep) exp_lens.push_back(n);
        @(negedge clk);
        mac_valid = 1'b0;
        mac_last  = 1'b0;
    endtask

    // monitor: pops one frame and compares it against the scoreboard
    task automatic drain_one(input string req);
        int len;
        int w = 0;
        while (fifo_info[23:16] == 8'd0 && w < 500) begin
            @(negedge clk);
            w++;
        end
        len = exp_lens.pop_front();
        check(sts_data == 16'(len), {req, " status length"}, int'(sts_data), len);
        sts_rd = 1'b1;
        @(negedge clk);
        sts_rd = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(host_data == e, {req, " byte"}, int'(host_data), int'(e));
            host_rd = 1'b1;
            @(negedge clk);
        end
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fifo_info == 32'd0, "R1 info", int'(fifo_info), 0);
        check(drop_count == '0, "R1 drop", int'(drop_count), 0);
        check(ffwd_busy == 1'b0, "R1 busy", int'(ffwd_busy), 0);

        // R4: count rises only one cycle after the last byte is accepted
        for (int i = 0; i < 12; i++) begin
            mac_valid = 1'b1; mac_data = 8'(7 + i); mac_last = (i == 11);
            exp_bytes.push_back(8'(7 + i));
            @(negedge clk);
        end
        exp_lens.push_back(12);
        mac_valid = 1'b0; mac_last = 1'b0;
        check(fifo_info[15:0] == 16'd0, "R4 partial hidden", int'(fifo_info[15:0]), 0);
        @(negedge clk);
        check(fifo_info[15:0] == 16'd12, "R4 committed", int'(fifo_info[15:0]), 12);
        drain_one("R2 single");

        // R2/R3: several sizes in order
        send_frame(1, 1'b1, 40);
        send_frame(5, 1'b1, 50);
        send_frame(40, 1'b1, 90);
        idle(4);
        check(fifo_info[15:0] == 16'd46, "R3 data bytes", int'(fifo_info[15:0]), 46);
        check(fifo_info[23:16] == 8'd3, "R3 status entries", int'(fifo_info[23:16]), 3);
        check(fifo_info[31:24] == 8'd0, "R3 top byte", int'(fifo_info[31:24]), 0);
        drain_one("R2 f1");
        drain_one("R2 f5");
        drain_one("R2 f40");
        check(fifo_info == 32'd0, "R3 empty", int'(fifo_info), 0);

        // R9/R10 fast-forward
        send_frame(20, 1'b1, 100);
        send_frame(4, 1'b1, 200);
        idle(4);
        check(sts_data == 16'd20, "R9 head length", int'(sts_data), 20);
        void'(exp_lens.pop_front());
        sts_rd = 1'b1; @(negedge clk); sts_rd = 1'b0;
        for (int i = 0; i < 3; i++) begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(host_data == e, "R9 pre-skip byte", int'(host_data), int'(e));
            host_rd = 1'b1; @(negedge clk);
        end
        host_rd = 1'b0;
        for (int i = 0; i < 17; i++) void'(exp_bytes.pop_front());
        ffwd_set = 1'b1;
        @(negedge clk);
        ffwd_set = 1'b0;
        check(ffwd_busy == 1'b1, "R10 busy set", int'(ffwd_busy), 1);
        host_rd = 1'b1;            // ignored during busy
        @(negedge clk);
        host_rd = 1'b0;
        check(ffwd_busy == 1'b0, "R10 busy cleared", int'(ffwd_busy), 0);
        check(fifo_info[15:0] == 16'd4, "R9 bytes left", int'(fifo_info[15:0]), 4);
        drain_one("R9 next frame");

        // R5/R6/R7: overrun while store full
        send_frame(60, 1'b1, 10);   // A kept
        send_frame(20, 1'b1, 150);  // E kept, mostly in staging
        send_frame(200, 1'b0, 33);  // F overruns
        send_frame(10, 1'b0, 77);   // C refused while blocked
        idle(5);
        check(fifo_info[15:0] == 16'd60, "R5 only A committed", int'(fifo_info[15:0]), 60);
        check(fifo_info[23:16] == 8'd1, "R5 no status for dropped", int'(fifo_info[23:16]), 1);
        check(drop_count == 3'd2, "R7 two drops", int'(drop_count), 2);
        for (int i = 0; i < 6; i++) send_frame(1, 1'b0, i);
        idle(2);
        check(drop_count == 3'd7, "R7 saturate", int'(drop_count), 7);
        drop_rd = 1'b1; @(negedge clk); drop_rd = 1'b0;
        check(drop_count == 3'd0, "R8 clear", int'(drop_count), 0);
        drain_one("R5 A intact");
        drain_one("R5 E intact");
        send_frame(10, 1'b1, 60);   // accepted again
        idle(4);
        check(drop_count == 3'd0, "R6 unblocked", int'(drop_count), 0);
        drain_one("R6 new frame");
        check(fifo_info == 32'd0, "R3 final empty", int'(fifo_info), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule